// File: doc/BRIEF.md
# Banked General-Purpose I/O Controller

This block drives and samples a set of general-purpose pins organised as banks of 32. Software reaches every bank through one word-wide register bus. Each bank keeps three stored registers: a direction mask, an input inversion mask and an output latch. It also has two write-only ports that raise or lower chosen output bits in a single write, so no read-modify-write is needed. Reading a bank's level register returns the driven value for output pins. For input pins it returns the synchronised pin level, inverted where the inversion mask is set.

The address map is built from a register group and a bank. Each group covers one kind of register for all banks. The group stride is 0x10 bytes and banks sit 4 bytes apart inside a group. The low two address bits are not decoded. The bus is a plain strobe interface with no wait states: a write takes effect at the clock edge where `bus_wr` is high, and read data is valid combinationally while `bus_rd` is high. Reset is asserted asynchronously and released on the clock through a two-flop stage.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The byte address is group index × 0x10 + bank × 0x4, and address bits [1:0] are ignored. Writing one bank never changes another bank's registers.
- R2: Group 0 is the direction mask. A 1 makes the pin an output and drives its `pin_oe` high, a 0 makes it an input. The mask reads back as written.
- R3: Group 1 is the inversion mask. It reads back as written, and for an input pin a 1 inverts the sampled level in level reads, while 0 leaves it unchanged.
- R4: Writing group 3 sets to 1 every output-latch bit whose data bit is 1, and leaves all other latch bits as they were.
- R5: Writing group 4 clears to 0 every output-latch bit whose data bit is 1, and leaves all other latch bits as they were.
- R6: Writing group 2 loads the whole output latch, and `pin_out` shows the latch for every pin.
- R7: Reading group 2 returns the latch bit for output pins. For input pins it returns `pin_in` XOR the inversion bit, after a two-stage synchroniser, so a pin change shows in the read starting two rising edges later.
- R8: Reads of groups 3 and 4 return 0. Writes to group indices 5 and above, or to bank numbers at or above `NUM_BANKS`, change nothing, and reads of them return 0. `bus_rdata` is 0 whenever `bus_rd` is low.
- R9: After reset, the direction mask, inversion mask and output latch of every bank are 0, so all pins are inputs with `pin_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NUM_BANKS×32 | Pin input levels |
| pin_oe | output | NUM_BANKS×32 | Per-pin output enable |
| pin_out | output | NUM_BANKS×32 | Per-pin output value |

## Verification
Some rules are checked on every cycle. A set write may only raise latch bits and a clear write may only lower them. A write to an unmapped address must leave both pin vectors unchanged. The bank decode selects at most one bank, and reads of the set and clear ports return zero. The stimulus scenarios are the only check of the full address map, the polarity inversion on input reads, the two-edge synchroniser latency, the mixing of driven and sampled bits in one level read, and the reset values.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REGS = 5;
  // group indices; order fixes the address map
  localparam int unsigned G_DIR = 0;
  localparam int unsigned G_POL = 1;
  localparam int unsigned G_LVL = 2;
  localparam int unsigned G_SET = 3;
  localparam int unsigned G_CLR = 4;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic [NUM_REGS-1:0]  grp_sel
);
  localparam int unsigned IDX_W = ADDR_W - 4;

  logic [1:0]       bank_f;
  logic [IDX_W-1:0] idx_f;
  logic [1:0]       unused_lo;

  assign bank_f    = addr[3:2];
  assign idx_f     = addr[ADDR_W-1:4];
  assign unused_lo = addr[1:0];

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_hit[b] = (bank_f == 2'(b));
    end
    for (int r = 0; r < NUM_REGS; r++) begin
      grp_sel[r] = (idx_f == IDX_W'(r));
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      q      <= '0;
    end else begin
      stg1_q <= d;
      q      <= stg1_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NUM_REGS-1:0] grp_sel,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [WORD_W-1:0]   pin_sync,
  output logic [WORD_W-1:0]   oe,
  output logic [WORD_W-1:0]   dout,
  output logic [WORD_W-1:0]   rdata
);
  logic [WORD_W-1:0] dir_q, dir_d, pol_q, pol_d, lat_q, lat_d;
  logic              dir_en, pol_en, lat_en;
  logic [WORD_W-1:0] set_mask, clr_mask;

  // next-state
  always_comb begin
    dir_en   = wr_en & grp_sel[G_DIR];
    pol_en   = wr_en & grp_sel[G_POL];
    lat_en   = wr_en & (grp_sel[G_LVL] | grp_sel[G_SET] | grp_sel[G_CLR]);
    set_mask = (wr_en & grp_sel[G_SET]) ? wdata : '0;
    clr_mask = (wr_en & grp_sel[G_CLR]) ? wdata : '0;
    dir_d    = wdata;
    pol_d    = wdata;
    if (grp_sel[G_LVL]) begin
      lat_d = wdata;
    end else begin
      lat_d = (lat_q | set_mask) & ~clr_mask;  // clear wins
    end
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      pol_q <= '0;
      lat_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (pol_en) pol_q <= pol_d;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign oe   = dir_q;
  assign dout = lat_q;

  always_comb begin
    rdata = '0;
    if (grp_sel[G_DIR]) rdata = dir_q;
    if (grp_sel[G_POL]) rdata = pol_q;
    if (grp_sel[G_LVL]) rdata = (dir_q & lat_q) | (~dir_q & (pin_sync ^ pol_q));
  end

  // R4: a set write only raises bits
  a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && grp_sel[G_SET]) |=> (dout == ($past(dout) | $past(wdata))));
  // R5: a clear write only lowers bits
  a_r5_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && grp_sel[G_CLR]) |=> (dout == ($past(dout) & ~$past(wdata))));
  // R2: direction holds when its group is not written
  a_r2_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && grp_sel[G_DIR]) |=> $stable(oe));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_BANKS*WORD_W-1:0]   pin_in,
  output logic [NUM_BANKS*WORD_W-1:0]   pin_oe,
  output logic [NUM_BANKS*WORD_W-1:0]   pin_out
);
  localparam int unsigned NP = NUM_BANKS * WORD_W;

  logic                 rst_s1_q, rst_s_n;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_REGS-1:0]  grp_sel;
  logic [NP-1:0]        pin_sync;
  logic [WORD_W-1:0]    bank_rdata [NUM_BANKS];
  logic [WORD_W-1:0]    rd_mux;

  // asynchronous assert, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s_n  <= rst_s1_q;
    end
  end

  gpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr     (bus_addr),
    .bank_hit (bank_hit),
    .grp_sel  (grp_sel)
  );

  gpio_sync #(.W(NP)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .wr_en    (bus_wr & bank_hit[b]),
      .grp_sel  (grp_sel),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync[b*WORD_W +: WORD_W]),
      .oe       (pin_oe[b*WORD_W +: WORD_W]),
      .dout     (pin_out[b*WORD_W +: WORD_W]),
      .rdata    (bank_rdata[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) rd_mux = rd_mux | bank_rdata[b];
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  // R1: at most one bank decoded
  a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(bank_hit));
  // R8: unmapped writes leave all pins untouched
  a_r8_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && ((bank_hit == '0) || (grp_sel == '0))) |=> ($stable(pin_oe) && $stable(pin_out)));
  // R8: set and clear ports read as zero
  a_r8_setclr_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && (grp_sel[G_SET] || grp_sel[G_CLR])) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int NP = NB * 32;
  localparam int NVEC = 21;
  // {write, addr, data-or-expected, requirement number}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, 8'h04, 32'hFFFF0000, 4'd2},  // R2 bank1 upper half outputs
    {1'b0, 8'h04, 32'hFFFF0000, 4'd2},  // R2 readback
    {1'b1, 8'h24, 32'h12345678, 4'd6},  // R6 load latch
    {1'b0, 8'h24, 32'h12340000, 4'd7},  // R7 mixed read
    {1'b1, 8'h34, 32'h000100FF, 4'd4},  // R4 set
    {1'b0, 8'h24, 32'h12350000, 4'd4},  // R4
    {1'b1, 8'h44, 32'h12000001, 4'd5},  // R5 clear
    {1'b0, 8'h24, 32'h00350000, 4'd5},  // R5
    {1'b0, 8'h34, 32'h00000000, 4'd8},  // R8 set port reads 0
    {1'b0, 8'h44, 32'h00000000, 4'd8},  // R8 clear port reads 0
    {1'b1, 8'h14, 32'h000000F0, 4'd3},  // R3 inversion mask
    {1'b0, 8'h14, 32'h000000F0, 4'd3},  // R3 readback
    {1'b0, 8'h24, 32'h003500F0, 4'd3},  // R3 inverted inputs
    {1'b1, 8'h0C, 32'hFFFFFFFF, 4'd8},  // R8 bank 3 absent
    {1'b0, 8'h0C, 32'h00000000, 4'd8},  // R8
    {1'b1, 8'h54, 32'hFFFFFFFF, 4'd8},  // R8 group 5 unused
    {1'b0, 8'h54, 32'h00000000, 4'd8},  // R8
    {1'b0, 8'h27, 32'h003500F0, 4'd1},  // R1 low bits ignored
    {1'b1, 8'h08, 32'h0000000F, 4'd1},  // R1 bank2 direction
    {1'b0, 8'h08, 32'h0000000F, 4'd1},  // R1
    {1'b0, 8'h00, 32'h00000000, 4'd1}   // R1 bank0 untouched
  };

  logic          clk, rst_n, bus_wr, bus_rd;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata, rd_val;
  logic [NP-1:0] pin_in, pin_oe, pin_out;
  int            n_checks, n_errors;
  bit            done;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9 reset state
    #1;
    check("R9 pin_oe", pin_oe, '0);
    check("R9 pin_out", pin_out, '0);
    bus_read(8'h14, rd_val);
    check("R9 inversion mask", NP'(rd_val), '0);
    // R8 idle read data
    #2 check("R8 rdata idle", NP'(bus_rdata), '0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][44]) begin
        bus_write(VEC[i][43:36], VEC[i][35:4]);
      end else begin
        bus_read(VEC[i][43:36], rd_val);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), NP'(rd_val), NP'(VEC[i][35:4]));
      end
    end

    // R2 / R6 pins after table, R8 ignored writes left nothing behind
    check("R2 pin_oe", pin_oe, {32'h0000000F, 32'hFFFF0000, 32'h0});
    check("R6 pin_out", pin_out, {32'h0, 32'h003556FE, 32'h0});

    // R7 synchroniser latency on bank1 pin 3
    @(negedge clk) pin_in[35] = 1'b1;
    bus_read(8'h24, rd_val);
    check("R7 one edge", NP'(rd_val), NP'(32'h003500F0));
    bus_read(8'h24, rd_val);
    check("R7 two edges", NP'(rd_val), NP'(32'h003500F8));
    // R3 inverted bit 4 driven high reads 0
    @(negedge clk) pin_in[36] = 1'b1;
    repeat (2) @(posedge clk);
    bus_read(8'h24, rd_val);
    check("R3 inverted high", NP'(rd_val), NP'(32'h003500E8));
    // R7 output pin ignores its input
    @(negedge clk) pin_in[63] = 1'b1;
    repeat (2) @(posedge clk);
    bus_read(8'h24, rd_val);
    check("R7 output ignores pin", NP'(rd_val), NP'(32'h003500E8));

    // R9 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R9 reset oe", pin_oe, '0);
    check("R9 reset out", pin_out, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    bus_read(8'h04, rd_val);
    check("R9 reset dir", NP'(rd_val), '0);

    done = 1'b1;
    finish_run();
  end
endmodule